// File: doc/BRIEF.md
# Indexed-Colour Display Controller Register File

This block is the host-facing control register file of an indexed-colour display controller. A host issues single-cycle accesses of byte, halfword or word size on a 32-bit data path. The block decodes the address and keeps the settings that the pixel pipeline consumes: the active width and height, the control word and the pixel depth decoded from it, the frame start offset, the pointer position, a 256-entry colour lookup table, a three-entry pointer colour table and a 512-entry two-bit-per-pixel pointer shape table.

The stored encodings are not the plain values. Width is written as a quarter of the pixel count and height as twice the line count. Each table entry occupies an 8-byte slot. A write narrower than 32 bits takes the word as it would read at that moment, replaces only the addressed lane, and stores the full word. The block drives one interrupt line. It raises the line when the refresh logic reports the end of a frame and lowers it on any host write. Writes to the video timing locations are accepted and discarded.

Top module: `gfx_regif`

## Requirements
- R1: A read of word offset 0x000000 returns 0x00000010. Writes to that offset change nothing.
- R2: A write of V to offset 0x080118 sets `width` to V*4, keeping 32 bits. A read returns `width`/4.
- R3: A write of V to offset 0x080150 sets `height` to V/2, rounded down. A read returns `height`*2, so an odd value written reads back one lower.
- R4: Bits 22:20 of the control word at offset 0x080300 set `depth`. Codes 0 to 7 give 1, 2, 4, 8, 15, 16, 0 and 0.
- R5: The colour table has one entry per 8 bytes from 0x080800 to 0x080FFF, so the entry index is address bits 10:3. An entry holds red in bits 23:16, green in 15:8 and blue in 7:0. The entry chosen by `pal_idx` appears on `pal_rgb` in the cycle after the write. Host reads of this range return 0.
- R6: The pointer colour table holds 3 readable entries at 0x080508, 0x080510 and 0x080518, packed the same way as R5. Bits 31:24 read as 0.
- R7: The pointer shape table holds 512 readable 16-bit entries, one per 8 bytes, starting at 0x081000. Bits 31:16 read as 0.
- R8: The frame start word at 0x080400 and the pointer position word at 0x080638 are readable and writable and drive `top` and `cursor_pos`. Writes to the timing locations (0x080000 and 0x080108 to 0x080200) change no other state, and those locations read 0.
- R9: A write to 0x180000 clears every register and table entry to zero and lowers `irq`.
- R10: Access size is 0 for a byte, 1 for a halfword and 2 or 3 for a word. A byte write replaces bits 8*a+7:8*a, where a is address bits 1:0. A halfword write replaces bits 31:16 when address bit 1 is set and bits 15:0 otherwise. The other bits keep the value the word read before the write.
- R11: A byte read returns the lane chosen by address bits 1:0 in bits 7:0. A halfword read returns the half chosen by address bit 1 in bits 15:0. All upper bits are 0.
- R12: `frame_done` sets `irq` in the next cycle. A write without `frame_done` clears it in the next cycle. When both occur in the same cycle, `frame_done` wins.
- R13: Every read raises `rvalid` in the next cycle with the data on `rdata`. An undecoded address reads 0 and gives no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, one cycle per access |
| we | input | 1 | 1 for write, 0 for read |
| size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| addr | input | ADDR_W | Byte address within the register space |
| wdata | input | 32 | Write data, right-aligned for narrow writes |
| rvalid | output | 1 | Read data valid, one cycle after a read |
| rdata | output | 32 | Read data |
| frame_done | input | 1 | End-of-frame pulse from the refresh logic |
| irq | output | 1 | Interrupt line |
| width | output | 32 | Active width in pixels |
| height | output | 32 | Active height in lines |
| depth | output | 5 | Decoded bits per pixel |
| ctrl | output | 32 | Control word |
| top | output | 32 | Frame start offset |
| cursor_pos | output | 32 | Pointer position word |
| pal_idx | input | PAL_IW | Colour table lookup index |
| pal_rgb | output | 24 | Colour table entry at `pal_idx` |

## Verification
The bench aims at the places where the stored encoding differs from the value seen on the bus.

- An odd height write must lose its low bit. A design that stores the raw value would read back the odd number.
- Narrow writes go into every lane of the control word and both halves of the frame start word. A design that zero-fills instead of merging would wipe the neighbouring lanes.
- Colour table entries are written at the odd-word alias of their slot. A decoder that used bit 2 would index the wrong entry.
- Colour table reads are checked to return 0 even after the table has been loaded.
- A write and an end-of-frame pulse land in the same cycle. A design with the wrong priority would leave `irq` low.
- A soft reset follows a fully loaded state. The check confirms the table lookup and the pointer shape read back zero.

// File: rtl/gfx_regif.sv
module gfx_regif #(
  parameter int ADDR_W = 21,
  parameter int PAL_N  = 256,
  parameter int PAT_N  = 512,
  localparam int PAL_IW = $clog2(PAL_N),
  localparam int PAT_IW = $clog2(PAT_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic              rvalid,
  output logic [31:0]       rdata,
  input  logic              frame_done,
  output logic              irq,
  output logic [31:0]       width,
  output logic [31:0]       height,
  output logic [4:0]        depth,
  output logic [31:0]       ctrl,
  output logic [31:0]       top,
  output logic [31:0]       cursor_pos,
  input  logic [PAL_IW-1:0] pal_idx,
  output logic [23:0]       pal_rgb
);
  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(32'h000000);
  localparam logic [ADDR_W-1:0] A_HD   = ADDR_W'(32'h080118);
  localparam logic [ADDR_W-1:0] A_VD   = ADDR_W'(32'h080150);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(32'h080300);
  localparam logic [ADDR_W-1:0] A_TOP  = ADDR_W'(32'h080400);
  localparam logic [ADDR_W-1:0] A_CPAL = ADDR_W'(32'h080500);
  localparam logic [ADDR_W-1:0] A_CPOS = ADDR_W'(32'h080638);
  localparam logic [ADDR_W-1:0] A_PAL  = ADDR_W'(32'h080800);
  localparam logic [ADDR_W-1:0] A_PAT  = ADDR_W'(32'h081000);
  localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(32'h180000);
  localparam int PAL_SH = PAL_IW + 3;
  localparam int PAT_SH = PAT_IW + 3;

  logic [23:0] pal  [PAL_N];
  logic [15:0] pat  [PAT_N];
  logic [23:0] cpal [3];
  logic [29:0] hraw;
  logic [30:0] vlines;
  logic [31:0] ctrl_q, top_q, cpos_q;

  logic [ADDR_W-1:0] aw;
  logic              hit_pal, hit_pat, hit_cpal, wr;
  logic [1:0]        cidx;
  logic [PAL_IW-1:0] lidx;
  logic [PAT_IW-1:0] sidx;
  logic [31:0]       cur, merged, lane;

  assign aw       = {addr[ADDR_W-1:2], 2'b00};
  assign hit_pal  = (aw >> PAL_SH) == (A_PAL >> PAL_SH);
  assign hit_pat  = (aw >> PAT_SH) == (A_PAT >> PAT_SH);
  assign hit_cpal = (aw >> 5) == (A_CPAL >> 5) && aw[4:3] != 2'd0;
  assign cidx     = aw[4:3] - 2'd1;
  assign lidx     = aw[PAL_SH-1:3];
  assign sidx     = aw[PAT_SH-1:3];
  assign wr       = req & we;

  always_comb begin
    cur = '0;
    if (hit_pat)       cur = {16'd0, pat[sidx]};
    else if (hit_cpal) cur = {8'd0, cpal[cidx]};
    else if (!hit_pal)
      case (aw)
        A_ID:    cur = 32'h10;
        A_HD:    cur = {2'b00, hraw};
        A_VD:    cur = {vlines, 1'b0};
        A_CTRL:  cur = ctrl_q;
        A_TOP:   cur = top_q;
        A_CPOS:  cur = cpos_q;
        default: cur = '0;
      endcase
  end

  always_comb begin
    merged = cur;
    case (size)
      2'd0: merged[{addr[1:0], 3'b000} +: 8] = wdata[7:0];
      2'd1: if (addr[1]) merged[31:16] = wdata[15:0];
            else         merged[15:0]  = wdata[15:0];
      default: merged = wdata;
    endcase
  end

  always_comb begin
    lane = cur >> {addr[1:0], 3'b000};
    case (size)
      2'd0:    lane = {24'd0, lane[7:0]};
      2'd1:    lane = addr[1] ? {16'd0, cur[31:16]} : {16'd0, cur[15:0]};
      default: lane = cur;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || (wr && aw == A_RST)) begin
      hraw   <= '0;
      vlines <= '0;
      ctrl_q <= '0;
      top_q  <= '0;
      cpos_q <= '0;
      for (int i = 0; i < PAL_N; i++) pal[i]  <= '0;
      for (int i = 0; i < PAT_N; i++) pat[i]  <= '0;
      for (int i = 0; i < 3; i++)     cpal[i] <= '0;
    end else if (wr) begin
      if (hit_pal)       pal[lidx]  <= merged[23:0];
      else if (hit_pat)  pat[sidx]  <= merged[15:0];
      else if (hit_cpal) cpal[cidx] <= merged[23:0];
      else
        case (aw)
          A_HD:   hraw   <= merged[29:0];
          A_VD:   vlines <= merged[31:1];
          A_CTRL: ctrl_q <= merged;
          A_TOP:  top_q  <= merged;
          A_CPOS: cpos_q <= merged;
          default: ;
        endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          irq <= 1'b0;
    else if (frame_done) irq <= 1'b1;
    else if (wr)         irq <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= req & ~we;
      if (req && !we) rdata <= lane;
    end
  end

  always_comb
    case (ctrl_q[22:20])
      3'd0:    depth = 5'd1;
      3'd1:    depth = 5'd2;
      3'd2:    depth = 5'd4;
      3'd3:    depth = 5'd8;
      3'd4:    depth = 5'd15;
      3'd5:    depth = 5'd16;
      default: depth = 5'd0;
    endcase

  assign width      = {hraw, 2'b00};
  assign height     = {1'b0, vlines};
  assign ctrl       = ctrl_q;
  assign top        = top_q;
  assign cursor_pos = cpos_q;
  assign pal_rgb    = pal[pal_idx];
endmodule

// File: rtl/gfx_regif_chk.sv
module gfx_regif_chk #(
  parameter int ADDR_W = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              we,
  input logic [1:0]        size,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              rvalid,
  input logic [31:0]       rdata,
  input logic              frame_done,
  input logic              irq,
  input logic [31:0]       width,
  input logic [31:0]       height,
  input logic [31:0]       ctrl
);
  localparam logic [ADDR_W-1:0] C_HD  = ADDR_W'(32'h080118);
  localparam logic [ADDR_W-1:0] C_VD  = ADDR_W'(32'h080150);
  localparam logic [ADDR_W-1:0] C_RST = ADDR_W'(32'h180000);

  a_r12_frame_raises: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> irq);

  a_r12_write_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && !frame_done) |=> !irq);

  a_r13_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we) |=> rvalid);

  a_r13_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && !we) |=> !rvalid);

  a_r1_id_value: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && size[1] && addr == '0) |=> rdata == 32'h10);

  a_r2_width_scaled: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && size[1] && addr == C_HD) |=> width == ($past(wdata) << 2));

  a_r3_height_halved: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && size[1] && addr == C_VD) |=> height == ($past(wdata) >> 1));

  a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && addr == C_RST) |=> (width == 0 && height == 0 && ctrl == 0));
endmodule

bind gfx_regif gfx_regif_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_gfx_regif.sv
module tb_gfx_regif;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, frame_done = 1'b0;
  logic [1:0]  size = 2'd2;
  logic [20:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  pal_idx = '0;
  logic        rvalid, irq;
  logic [31:0] rdata, width, height, ctrl, top, cursor_pos;
  logic [4:0]  depth;
  logic [23:0] pal_rgb;

  int checks = 0, fails = 0;
  bit done = 0;

  gfx_regif dut (.*);

  always #10 clk = ~clk;

  logic [23:0] m_pal [256];
  logic [15:0] m_pat [512];
  logic [23:0] m_cpal[3];
  logic [31:0] m_w, m_h, m_ctrl, m_top, m_cpos, m_rdata;
  logic        m_irq, m_rvalid;

  task automatic m_clear();
    for (int i = 0; i < 256; i++) m_pal[i] = '0;
    for (int i = 0; i < 512; i++) m_pat[i] = '0;
    for (int i = 0; i < 3; i++)   m_cpal[i] = '0;
    m_w = 0; m_h = 0; m_ctrl = 0; m_top = 0; m_cpos = 0;
  endtask

  function automatic logic [31:0] m_word(input logic [20:0] a);
    int unsigned w = a & ~21'd3;
    if (w >= 32'h081000 && w < 32'h082000) return {16'd0, m_pat[(w - 32'h081000) / 8]};
    if (w >= 32'h080508 && w < 32'h080520) return {8'd0, m_cpal[(w - 32'h080508) / 8]};
    case (w)
      32'h000000: return 32'h10;
      32'h080118: return m_w / 4;
      32'h080150: return m_h * 2;
      32'h080300: return m_ctrl;
      32'h080400: return m_top;
      32'h080638: return m_cpos;
      default:    return 0;
    endcase
  endfunction

  function automatic logic [4:0] m_depth(input logic [31:0] c);
    case ((c >> 20) & 7)
      0: return 1;  1: return 2;  2: return 4;
      3: return 8;  4: return 15; 5: return 16;
      default: return 0;
    endcase
  endfunction

  task automatic m_write(input logic [20:0] a, input logic [1:0] sz, input logic [31:0] d);
    logic [31:0] old = m_word(a), nv;
    int unsigned w = a & ~21'd3;
    int sh;
    if (sz == 0) begin
      sh = 8 * (a % 4);
      nv = (old & ~(32'hFF << sh)) | ((d & 32'hFF) << sh);
    end else if (sz == 1) begin
      sh = a[1] ? 16 : 0;
      nv = (old & ~(32'hFFFF << sh)) | ((d & 32'hFFFF) << sh);
    end else nv = d;
    if (w == 32'h180000) m_clear();
    else if (w >= 32'h080800 && w < 32'h081000) m_pal[(w - 32'h080800) / 8] = nv[23:0];
    else if (w >= 32'h081000 && w < 32'h082000) m_pat[(w - 32'h081000) / 8] = nv[15:0];
    else if (w >= 32'h080508 && w < 32'h080520) m_cpal[(w - 32'h080508) / 8] = nv[23:0];
    else case (w)
      32'h080118: m_w = nv * 4;
      32'h080150: m_h = nv / 2;
      32'h080300: m_ctrl = nv;
      32'h080400: m_top = nv;
      32'h080638: m_cpos = nv;
      default: ;
    endcase
  endtask

  function automatic logic [31:0] m_lane(input logic [20:0] a, input logic [1:0] sz);
    logic [31:0] w = m_word(a);
    if (sz == 0) return (w >> (8 * (a % 4))) & 32'hFF;
    if (sz == 1) return a[1] ? (w >> 16) : (w & 32'hFFFF);
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare(input string rtag);
    chk("R12 irq", {31'd0, irq}, {31'd0, m_irq});
    chk("R2 width", width, m_w);
    chk("R3 height", height, m_h);
    chk("R4 depth", {27'd0, depth}, {27'd0, m_depth(m_ctrl)});
    chk("R10 ctrl", ctrl, m_ctrl);
    chk("R8 top", top, m_top);
    chk("R8 cursor_pos", cursor_pos, m_cpos);
    chk("R5 pal_rgb", {8'd0, pal_rgb}, {8'd0, m_pal[pal_idx]});
    chk("R13 rvalid", {31'd0, rvalid}, {31'd0, m_rvalid});
    if (m_rvalid) chk(rtag, rdata, m_rdata);
  endtask

  task automatic op(input logic r, input logic w, input logic [1:0] sz,
                    input logic [20:0] a, input logic [31:0] d,
                    input logic fd, input string tag);
    req = r; we = w; size = sz; addr = a; wdata = d; frame_done = fd;
    @(posedge clk);
    #1;
    m_rvalid = r & ~w;
    if (r && !w) m_rdata = m_lane(a, sz);
    if (fd) m_irq = 1;
    else if (r && w) m_irq = 0;
    if (r && w) m_write(a, sz, d);
    @(negedge clk);
    req = 0; we = 0; frame_done = 0;
    compare(tag);
  endtask

  task automatic wr32(input logic [20:0] a, input logic [31:0] d, input string t);
    op(1, 1, 2, a, d, 0, t);
  endtask
  task automatic rd(input logic [20:0] a, input logic [1:0] sz, input string t);
    op(1, 0, sz, a, 0, 0, t);
  endtask
  task automatic idle(input string t);
    op(0, 0, 2, 0, 0, 0, t);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_clear();
    m_irq = 0; m_rvalid = 0; m_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle("R9 reset state");

    rd(21'h000000, 2, "R1 id read");
    wr32(21'h000000, 32'hFFFF_FFFF, "R1 id write");
    rd(21'h000000, 2, "R1 id after write");

    wr32(21'h080118, 32'h0000_0140, "R2 width write");
    rd(21'h080118, 2, "R2 width read");
    wr32(21'h080118, 32'hC000_0003, "R2 width wrap");
    rd(21'h080118, 2, "R2 width wrap read");

    wr32(21'h080150, 32'h0000_03C1, "R3 odd height write");
    rd(21'h080150, 2, "R3 odd height read");

    for (int c = 0; c < 8; c++) wr32(21'h080300, c << 20, "R4 depth code");

    pal_idx = 8'd5;
    wr32(21'h080800 + 5 * 8, 32'hFF12_3456, "R5 pal write");
    wr32(21'h080800 + 9 * 8 + 4, 32'h00AB_CDEF, "R5 pal alias write");
    pal_idx = 8'd9; idle("R5 pal alias lookup");
    wr32(21'h080FF8, 32'h0001_0203, "R5 pal last");
    pal_idx = 8'd255; idle("R5 pal last lookup");
    rd(21'h080800 + 5 * 8, 2, "R5 pal read zero");
    op(1, 1, 0, 21'h080FF9, 32'h0000_0077, 0, "R5 pal byte merge");
    idle("R5 pal byte merge lookup");

    for (int i = 0; i < 3; i++) begin
      wr32(21'h080508 + i * 8, 32'hAA00_0000 | (32'h10_2030 * (i + 1)), "R6 cursor pal write");
      rd(21'h080508 + i * 8, 2, "R6 cursor pal read");
    end

    wr32(21'h081000, 32'hDEAD_BEEF, "R7 pattern first");
    wr32(21'h081000 + 511 * 8, 32'h1234_5678, "R7 pattern last");
    rd(21'h081000, 2, "R7 pattern first read");
    rd(21'h081000 + 511 * 8, 2, "R7 pattern last read");
    rd(21'h081000 + 8, 2, "R7 pattern untouched");

    wr32(21'h080400, 32'h0012_3400, "R8 top write");
    wr32(21'h080638, 32'h0040_0020, "R8 cursor pos write");
    rd(21'h080400, 2, "R8 top read");
    rd(21'h080638, 2, "R8 cursor pos read");
    wr32(21'h080000, 32'hFFFF_FFFF, "R8 boot discard");
    wr32(21'h080108, 32'hFFFF_FFFF, "R8 timing discard");
    wr32(21'h080200, 32'hFFFF_FFFF, "R8 mask discard");
    rd(21'h080108, 2, "R8 timing read zero");

    wr32(21'h080300, 32'h0000_0000, "R10 clear ctrl");
    for (int b = 0; b < 4; b++) op(1, 1, 0, 21'h080300 + b, 32'hA0 + b, 0, "R10 byte lane");
    op(1, 1, 1, 21'h080402, 32'hBEEF, 0, "R10 upper half");
    op(1, 1, 1, 21'h080400, 32'hCAFE, 0, "R10 lower half");
    op(1, 1, 0, 21'h080152, 32'h0000_0005, 0, "R10 byte into height");
    rd(21'h080150, 2, "R10 height merged");

    for (int b = 0; b < 4; b++) rd(21'h080300 + b, 0, "R11 byte read");
    rd(21'h080402, 1, "R11 upper half read");
    rd(21'h080401, 1, "R11 half ignores bit0");
    rd(21'h081000 + 3, 0, "R11 pattern top byte");

    op(0, 0, 2, 0, 0, 1, "R12 frame raises");
    idle("R12 stays high");
    rd(21'h000000, 2, "R12 read keeps irq");
    wr32(21'h0ABCD0, 0, "R12 write lowers");
    op(0, 0, 2, 0, 0, 1, "R12 raise again");
    op(1, 1, 2, 21'h080400, 32'h55, 1, "R12 frame wins");

    rd(21'h0ABCD0, 2, "R13 undecoded read");
    rd(21'h1FFFFC, 0, "R13 undecoded byte");

    pal_idx = 8'd5;
    wr32(21'h180000, 32'h0, "R9 soft reset");
    idle("R9 pal cleared");
    rd(21'h081000, 2, "R9 pattern cleared");
    rd(21'h080508, 2, "R9 cursor pal cleared");
    rd(21'h080118, 2, "R9 width cleared");
    op(0, 0, 2, 0, 0, 1, "R9 raise before reset");
    wr32(21'h180004, 32'h0, "R9 reset word lowers irq");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule